// File: doc/BRIEF.md
# Multiply-Accumulate Arithmetic Slice

This block is one pipelined arithmetic slice of a larger datapath fabric. It multiplies two 18-bit two's-complement operands and sign-extends the 36-bit product to 48 bits. It does not add the product on its own. Instead, three operand selectors route the product, the 48-bit `c_in` word, the slice's own registered result and the neighbour's cascade word into a shared 48-bit three-input adder/subtractor. That stage computes `P = Z + (X + Y + carry)` or `P = Z - (X + Y + carry)`.

Because the registered result can be routed back in, the slice works as an accumulator, as a plain adder, or as a stage in a chain of slices. In a chain, each slice reads the cascade output of its neighbour, either directly or shifted right arithmetically by 17 bits to build wider products.

The slice is a fixed-latency pipeline with no per-transfer handshake. One clock enable acts as the stall for the whole slice and freezes every register in the same cycle. The caller must hold `a_in` and `b_in` for as long as the operand registers are expected to keep them. The word that leaves the slice is the result register, and it is valid on every cycle.

Top module: `mac_slice`

## Requirements
- R1: With X selecting the product, the result is the signed product of `a_in` and `b_in`, sign-extended to 48 bits. This includes the corner operands 0, 1, -1, +131071 and -131072.
- R2: `mode[1:0]` picks X: 00 gives zero, 01 gives the product, 10 gives the result register and 11 gives zero.
- R3: `mode[3:2]` picks Y: 10 gives `c_in`, and 00, 01 and 11 give zero. Code 01 is the partial-product slot, which is empty because the full product travels on X.
- R4: `mode[6:4]` picks Z: 000 gives zero, 001 gives the result register, 010 gives `c_in` and 011 gives `casc_in` shifted right arithmetically by 17. Codes 100 to 111 give zero.
- R5: With `sub`=0 the next result is Z+X+Y+`carry_in`. With `sub`=1 it is Z-(X+Y+`carry_in`). Both are taken modulo 2^48.
- R6: `a_in` and `b_in` pass through an operand register and a product register before they reach the result register. A new operand pair therefore reaches `p_out` at the third enabled edge. `mode`, `sub`, `carry_in`, `c_in` and `casc_in` are sampled at the edge that loads the result.
- R7: Selecting the result register on X or Z adds the previous result, which gives running accumulation.
- R8: While `ce` is low, every register holds its value and `p_out` does not change.
- R9: A synchronous `rst` clears every register, so `p_out` is 0 after that edge. `rst` wins over `ce`.
- R10: `casc_out` equals `p_out` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| a_in | input | 18 | Multiplier operand A, two's complement |
| b_in | input | 18 | Multiplier operand B, two's complement |
| c_in | input | 48 | Wide addend word |
| casc_in | input | 48 | Cascade word from the neighbouring slice |
| mode | input | 7 | Operand selectors: Z in [6:4], Y in [3:2], X in [1:0] |
| sub | input | 1 | 1 selects subtraction of X+Y+carry from Z |
| carry_in | input | 1 | Carry added into X+Y |
| p_out | output | 48 | Registered result |
| casc_out | output | 48 | Cascade word to the next slice, equal to the result |

## Verification
A corrupted operand or product register shows up as a wrong result exactly two or one enabled edges after the bad value is loaded. This is because each register holds a word for only one enabled cycle. A wrong value in the result register is visible on `p_out` and `casc_out` in the same cycle. When the slice is accumulating, that error also carries into every later result. This makes a stuck or stale register easy to expose: the bench compares the result against an arithmetic reference on every cycle while it sweeps every selector code, both directions of subtraction, stalls and resets.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int MODE_W = 7;

  // X selector codes
  localparam logic [1:0] XS_ZERO  = 2'b00;
  localparam logic [1:0] XS_PROD  = 2'b01;
  localparam logic [1:0] XS_RES   = 2'b10;

  // Y selector codes
  localparam logic [1:0] YS_ZERO  = 2'b00;
  localparam logic [1:0] YS_PHALF = 2'b01;
  localparam logic [1:0] YS_WIDE  = 2'b10;

  // Z selector codes
  localparam logic [2:0] ZS_ZERO  = 3'b000;
  localparam logic [2:0] ZS_RES   = 3'b001;
  localparam logic [2:0] ZS_WIDE  = 3'b010;
  localparam logic [2:0] ZS_CASC  = 3'b011;

  typedef struct packed {
    logic [2:0] zsel;
    logic [1:0] ysel;
    logic [1:0] xsel;
  } mode_t;

endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int W  = 18,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;

      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end

      assign q = q_r;

      // R8: a stalled stage keeps its word
      p_stage_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q_r));
    end else begin : g_bypass
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int AW   = 18,
  parameter int BW   = 18,
  parameter int PW   = 48,
  parameter bit AREG = 1'b1,
  parameter bit BREG = 1'b1,
  parameter bit MREG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [PW-1:0] prod_ext
);

  localparam int PRW = AW + BW;
  localparam int EXW = PW - PRW;

  logic [AW-1:0]         a_q;
  logic [BW-1:0]         b_q;
  logic signed [PRW-1:0] prod_raw;
  logic [PW-1:0]         prod_wide;

  mac_pipe_reg #(.W(AW), .EN(AREG)) u_areg (
    .clk(clk), .rst(rst), .ce(ce), .d(a), .q(a_q)
  );

  mac_pipe_reg #(.W(BW), .EN(BREG)) u_breg (
    .clk(clk), .rst(rst), .ce(ce), .d(b), .q(b_q)
  );

  always_comb begin
    prod_raw  = $signed(a_q) * $signed(b_q);
    prod_wide = {{EXW{prod_raw[PRW-1]}}, prod_raw};
  end

  mac_pipe_reg #(.W(PW), .EN(MREG)) u_mreg (
    .clk(clk), .rst(rst), .ce(ce), .d(prod_wide), .q(prod_ext)
  );

  generate
    if (MREG) begin : g_mchk
      // R1: a zero operand yields a zero product one stage later
      p_zero_operand_r1: assert property (@(posedge clk) disable iff (rst)
        (ce && (a_q == '0 || b_q == '0)) |=> (prod_ext == '0));
    end
  endgenerate

endmodule

// File: rtl/mac_opnd_mux.sv
module mac_opnd_mux
  import mac_pkg::*;
#(
  parameter int PW     = 48,
  parameter int CSHIFT = 17
) (
  input  mode_t         sel,
  input  logic [PW-1:0] prod,
  input  logic [PW-1:0] res,
  input  logic [PW-1:0] wide,
  input  logic [PW-1:0] casc,
  output logic [PW-1:0] x,
  output logic [PW-1:0] y,
  output logic [PW-1:0] z
);

  logic signed [PW-1:0] casc_s;
  logic [PW-1:0]        casc_sh;

  always_comb begin
    casc_s  = $signed(casc);
    casc_sh = casc_s >>> CSHIFT;
  end

  always_comb begin
    case (sel.xsel)
      XS_PROD: x = prod;
      XS_RES:  x = res;
      default: x = '0;
    endcase
  end

  always_comb begin
    case (sel.ysel)
      YS_WIDE:  y = wide;
      YS_PHALF: y = '0;
      default:  y = '0;
    endcase
  end

  always_comb begin
    case (sel.zsel)
      ZS_RES:  z = res;
      ZS_WIDE: z = wide;
      ZS_CASC: z = casc_sh;
      default: z = '0;
    endcase
  end

endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
  parameter int PW = 48
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  input  logic          sub,
  input  logic          cin,
  output logic [PW-1:0] sum
);

  logic [PW-1:0] xy;

  always_comb begin
    xy  = x + y + {{(PW-1){1'b0}}, cin};
    sum = sub ? (z - xy) : (z + xy);
  end

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_pkg::*;
#(
  parameter int AW     = 18,
  parameter int BW     = 18,
  parameter int PW     = 48,
  parameter int CSHIFT = 17,
  parameter bit AREG   = 1'b1,
  parameter bit BREG   = 1'b1,
  parameter bit MREG   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [AW-1:0]     a_in,
  input  logic [BW-1:0]     b_in,
  input  logic [PW-1:0]     c_in,
  input  logic [PW-1:0]     casc_in,
  input  logic [MODE_W-1:0] mode,
  input  logic              sub,
  input  logic              carry_in,
  output logic [PW-1:0]     p_out,
  output logic [PW-1:0]     casc_out
);

  logic [PW-1:0] prod_ext;
  logic [PW-1:0] x_op, y_op, z_op, sum;
  logic [PW-1:0] p_q;
  mode_t         sel;

  assign sel = mode_t'(mode);

  mac_mult #(
    .AW(AW), .BW(BW), .PW(PW), .AREG(AREG), .BREG(BREG), .MREG(MREG)
  ) u_mult (
    .clk(clk), .rst(rst), .ce(ce), .a(a_in), .b(b_in), .prod_ext(prod_ext)
  );

  mac_opnd_mux #(.PW(PW), .CSHIFT(CSHIFT)) u_mux (
    .sel(sel), .prod(prod_ext), .res(p_q), .wide(c_in), .casc(casc_in),
    .x(x_op), .y(y_op), .z(z_op)
  );

  mac_addsub #(.PW(PW)) u_add (
    .x(x_op), .y(y_op), .z(z_op), .sub(sub), .cin(carry_in), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst)     p_q <= '0;
    else if (ce) p_q <= sum;
  end

  assign p_out    = p_q;
  assign casc_out = p_q;

  // R8: stalled result does not move
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(p_out));

  // R5: all-zero selection without carry gives zero
  p_zero_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && mode == '0 && !sub && !carry_in) |=> (p_out == '0));

  // R5: carry alone adds one
  p_carry_only_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && mode == '0 && !sub && carry_in) |=> (p_out == {{(PW-1){1'b0}}, 1'b1}));

  // R7: feeding back the result with nothing else keeps it
  p_acc_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && mode == {ZS_RES, YS_ZERO, XS_ZERO} && !sub && !carry_in)
      |=> $stable(p_out));

endmodule

// File: tb/mac_slice_tb.sv
module mac_slice_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce  = 1'b1;
  logic [17:0] a_in = '0, b_in = '0;
  logic [47:0] c_in = '0, casc_in = '0;
  logic [6:0]  mode = '0;
  logic        sub = 1'b0, carry_in = 1'b0;
  logic [47:0] p_out, casc_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  string tag = "R9";
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_slice dut_i (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .casc_in(casc_in), .mode(mode), .sub(sub), .carry_in(carry_in),
    .p_out(p_out), .casc_out(casc_out)
  );

  // Arithmetic reference derived from the requirements
  logic [17:0] ra, rb;
  logic [47:0] rm, rp;

  function automatic logic [47:0] ref_next();
    logic [47:0] xv, yv, zv, s;
    logic signed [47:0] cs;
    xv = (mode[1:0] == 2'b01) ? rm : (mode[1:0] == 2'b10) ? rp : 48'd0;
    yv = (mode[3:2] == 2'b10) ? c_in : 48'd0;
    cs = casc_in;
    case (mode[6:4])
      3'b001:  zv = rp;
      3'b010:  zv = c_in;
      3'b011:  zv = 48'(cs >>> 17);
      default: zv = 48'd0;
    endcase
    s = xv + yv + 48'(carry_in);
    return sub ? 48'(zv + ~s + 48'd1) : 48'(zv + s);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      ra <= '0; rb <= '0; rm <= '0; rp <= '0;
    end else if (ce) begin
      ra <= a_in;
      rb <= b_in;
      rm <= 48'(longint'($signed(ra)) * longint'($signed(rb)));
      rp <= ref_next();
    end
  end

  always @(posedge clk) begin
    if (cyc == WATCHDOG) begin
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WATCHDOG);
      bad = bad + 1;
      total = total + 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check_now();
    total = total + 1;
    if (p_out !== rp) begin
      bad = bad + 1;
      $display("FAIL %s: p_out actual=%h expected=%h", tag, p_out, rp);
    end
    total = total + 1;
    if (casc_out !== p_out) begin
      bad = bad + 1;
      $display("FAIL R10: casc_out actual=%h expected=%h", casc_out, p_out);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_now();
  endtask

  task automatic rand_data();
    a_in    = rnd()[17:0];
    b_in    = rnd()[17:0];
    c_in    = {rnd()[15:0], rnd()};
    casc_in = {rnd()[15:0], rnd()};
  endtask

  logic [17:0] corners [8];

  initial begin
    corners[0] = 18'h00000; corners[1] = 18'h00001; corners[2] = 18'h3FFFF;
    corners[3] = 18'h1FFFF; corners[4] = 18'h20000; corners[5] = 18'h00002;
    corners[6] = 18'h3FFFE; corners[7] = 18'h15555;

    // R9: reset state
    tag = "R9";
    tick(); tick();
    rst = 1'b0;

    // R1: corner operand sweep, X = product
    tag = "R1";
    mode = 7'b000_00_01;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a_in = corners[i]; b_in = corners[j];
        tick();
      end
    end
    repeat (3) tick();

    // R6: single-cycle operand pulse, latency
    tag = "R6";
    a_in = 18'd5; b_in = 18'd7;
    tick();
    a_in = '0; b_in = '0;
    repeat (4) tick();

    // R2: every X code
    tag = "R2";
    for (int k = 0; k < 200; k++) begin
      rand_data(); mode = {3'b000, 2'b00, 2'(k % 4)}; carry_in = rnd()[0];
      tick();
    end

    // R3: every Y code
    tag = "R3";
    carry_in = 1'b0;
    for (int k = 0; k < 120; k++) begin
      rand_data(); mode = {3'b000, 2'(k % 4), 2'b00};
      tick();
    end

    // R4: every Z code including cascade shift
    tag = "R4";
    for (int k = 0; k < 240; k++) begin
      rand_data(); mode = {3'(k % 8), 2'b00, 2'b00};
      tick();
    end

    // R5: add and subtract over random modes
    tag = "R5";
    for (int k = 0; k < 400; k++) begin
      rand_data(); mode = rnd()[6:0]; sub = rnd()[0]; carry_in = rnd()[1];
      tick();
    end
    sub = 1'b0; carry_in = 1'b0;

    // R7: accumulation through Z and through X
    tag = "R7";
    for (int k = 0; k < 100; k++) begin
      a_in = 18'(rnd()[9:0]); b_in = 18'(rnd()[9:0]);
      mode = (k < 50) ? 7'b001_00_01 : 7'b010_00_10;
      tick();
    end

    // R8: clock-enable stalls
    tag = "R8";
    for (int k = 0; k < 300; k++) begin
      rand_data(); mode = rnd()[6:0]; sub = rnd()[0]; carry_in = rnd()[1];
      ce = rnd()[2] | rnd()[3];
      tick();
    end

    // R9: reset pulses, including with ce low
    tag = "R9";
    for (int k = 0; k < 300; k++) begin
      rand_data(); mode = rnd()[6:0]; sub = rnd()[0]; carry_in = rnd()[1];
      ce  = rnd()[2];
      rst = (rnd()[4:0] == 5'd0);
      tick();
    end
    rst = 1'b0; ce = 1'b1;
    repeat (4) tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule